// File: doc/BRIEF.md
# Crossing-Labelled Event Builder

This block collects data fragments from several sources. Each source sends a fragment only when its data is ready, and every fragment carries the crossing label (bunch-crossing timestamp) of the data it holds. A source's transmission time may vary, so the fragments of one event can arrive spread over several crossings, in any order, and several sources can deliver in the same clock. Fragments that share a label are merged into one event, which is held in one of a small set of slots selected by the low bits of the label.

Each crossing label unit is one crossing period, and the crossing counter `bx_now` advances by one on every clock. An event is never released early. It waits exactly `LATENCY` crossings after its label and then leaves on the output, whether or not every source has reported. Downstream logic therefore sees a synchronous pipeline with a fixed delay, and the time-out and the fixed release point are the same instant. A fragment that arrives after its event has left, or that carries a label from the future, is discarded and counted. A second fragment from the same source for the same label is also discarded and counted.

Top module: `bx_event_builder`

## Requirements
- R1: While `rst_n` is low and after it is released, `ev_valid` is 0, `drop_cnt` is 0 and no slot holds any fragment.
- R2: A fragment with label `T` that is presented while the counter reads `B` is accepted only when the age `(B - T) mod 2^TS_W` is below `LATENCY`. Otherwise it is dropped. This covers a label whose event has already left, and a label that is ahead of the counter.
- R3: Accepted fragments that carry the same label form one event. Bit `k` of `ev_mask` is 1 exactly when source `k` delivered a fragment for that event.
- R4: The event with label `T` is emitted once, as a one-cycle `ev_valid` pulse with `ev_ts = T`. The pulse is registered at the clock edge at which `bx_now` equals `(T + LATENCY) mod 2^TS_W`.
- R5: `ev_incomplete` is 1 on an emitted event exactly when at least one bit of `ev_mask` is 0.
- R6: An event whose mask is already full is still held until its fixed release edge from R4. It is never emitted earlier.
- R7: When a source delivers a second fragment for a label it has already supplied, the first data is kept and the second fragment is dropped.
- R8: `drop_cnt` rises by the number of fragments dropped in a cycle (under R2 and R7), which can be several in one cycle. It wraps modulo `2^CNT_W`.
- R9: Field `k` of `ev_data` (bits `k*DATA_W` upward) carries source `k`'s accepted data when mask bit `k` is 1, and zero when it is 0.
- R10: A label for which no fragment was accepted produces no `ev_valid` pulse.
- R11: Fragments from different sources arriving in the same cycle are each handled independently, whether they carry the same label or different labels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crossing-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| frag_vld | input | NUM_SRC | One fragment strobe per source |
| frag_ts | input | NUM_SRC*TS_W | Crossing label for each source, with source k at bits k*TS_W |
| frag_data | input | NUM_SRC*DATA_W | Fragment payload for each source, with source k at bits k*DATA_W |
| bx_now | input | TS_W | Free-running crossing counter, advancing by one per clock |
| ev_valid | output | 1 | Event released this cycle |
| ev_ts | output | TS_W | Label of the released event |
| ev_mask | output | NUM_SRC | Sources that reported for the released event |
| ev_incomplete | output | 1 | Released event is missing at least one source |
| ev_data | output | NUM_SRC*DATA_W | Payloads of the released event, zero for absent sources |
| drop_cnt | output | CNT_W | Running count of discarded fragments |

## Verification
Release of one label and admission of fragments can fall in the same clock. A fragment for the label being released arrives exactly `LATENCY` crossings old, so it is refused. In that same edge a fragment `LATENCY-1` crossings old must still join its own event, and a full event must leave no earlier than its fixed edge. The bench provokes these cases by driving fragments at chosen ages relative to the counter, including the edge on which the counter wraps. A behavioural model keeps per-label masks and payloads in associative arrays and predicts each edge's release and drop count. The outputs are then compared with the model on every clock.

// File: rtl/bxeb_pkg.sv
package bxeb_pkg;

  // Classification of one source's input in one cycle
  typedef enum logic [1:0] {
    FR_IDLE = 2'd0,
    FR_TAKE = 2'd1,
    FR_LATE = 2'd2,
    FR_DUP  = 2'd3
  } frag_verdict_e;

endpackage

// File: rtl/bxeb_frag_gate.sv
module bxeb_frag_gate
  import bxeb_pkg::*;
#(
  parameter int TS_W     = 12,
  parameter int NUM_SLOT = 8,
  parameter int LATENCY  = 5,
  localparam int SLOT_W  = $clog2(NUM_SLOT)
) (
  input  logic                frag_vld,
  input  logic [TS_W-1:0]     frag_ts,
  input  logic [TS_W-1:0]     bx_now,
  input  logic [NUM_SLOT-1:0] slot_has,
  output frag_verdict_e       verdict,
  output logic [SLOT_W-1:0]   slot_idx
);

  localparam logic [TS_W-1:0] LAT_V = TS_W'(LATENCY);

  logic [TS_W-1:0] age;

  // Age wraps with the counter; labels ahead of the counter look very old
  always_comb begin
    age      = bx_now - frag_ts;
    slot_idx = frag_ts[SLOT_W-1:0];
    if (!frag_vld) begin
      verdict = FR_IDLE;
    end else if (age >= LAT_V) begin
      verdict = FR_LATE;
    end else if (slot_has[slot_idx]) begin
      verdict = FR_DUP;
    end else begin
      verdict = FR_TAKE;
    end
  end

endmodule

// File: rtl/bxeb_slot_bank.sv
module bxeb_slot_bank #(
  parameter int NUM_SRC  = 4,
  parameter int NUM_SLOT = 8,
  parameter int DATA_W   = 8,
  localparam int SLOT_W  = $clog2(NUM_SLOT)
) (
  input  logic                                           clk,
  input  logic                                           rst_n,
  input  logic [NUM_SRC-1:0]                             take,
  input  logic [NUM_SRC-1:0][SLOT_W-1:0]                 take_slot,
  input  logic [NUM_SRC-1:0][DATA_W-1:0]                 take_data,
  input  logic [SLOT_W-1:0]                              rel_slot,
  output logic [NUM_SLOT-1:0][NUM_SRC-1:0]               mask_q,
  output logic [NUM_SLOT-1:0][NUM_SRC-1:0][DATA_W-1:0]   data_q
);

  logic [NUM_SLOT-1:0][NUM_SRC-1:0] mask_d;
  logic [NUM_SLOT-1:0][NUM_SRC-1:0] data_en;

  // Next state: the released slot empties; admitted fragments set their bit
  always_comb begin
    for (int s = 0; s < NUM_SLOT; s++) begin
      for (int k = 0; k < NUM_SRC; k++) begin
        data_en[s][k] = take[k] && (take_slot[k] == SLOT_W'(s));
        if (data_en[s][k]) begin
          mask_d[s][k] = 1'b1;
        end else if (rel_slot == SLOT_W'(s)) begin
          mask_d[s][k] = 1'b0;
        end else begin
          mask_d[s][k] = mask_q[s][k];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      data_q <= '0;
    end else begin
      mask_q <= mask_d;
      for (int s = 0; s < NUM_SLOT; s++) begin
        for (int k = 0; k < NUM_SRC; k++) begin
          if (data_en[s][k]) begin
            data_q[s][k] <= take_data[k];
          end
        end
      end
    end
  end

  // A slot being released is never the target of an admitted fragment
  for (genvar k = 0; k < NUM_SRC; k++) begin : g_chk
    AST_NO_TAKE_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      take[k] |-> (take_slot[k] != rel_slot)); // R2
  end

  AST_SLOT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (mask_q[$past(rel_slot)] == '0)); // R4

endmodule

// File: rtl/bxeb_emit.sv
module bxeb_emit #(
  parameter int NUM_SRC = 4,
  parameter int TS_W    = 12,
  parameter int DATA_W  = 8,
  parameter int CNT_W   = 16,
  localparam int DROP_W = $clog2(NUM_SRC + 1)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [TS_W-1:0]                  rel_ts,
  input  logic [NUM_SRC-1:0]               rel_mask,
  input  logic [NUM_SRC-1:0][DATA_W-1:0]   rel_data,
  input  logic [DROP_W-1:0]                drop_n,
  output logic                             ev_valid,
  output logic [TS_W-1:0]                  ev_ts,
  output logic [NUM_SRC-1:0]               ev_mask,
  output logic                             ev_incomplete,
  output logic [NUM_SRC*DATA_W-1:0]        ev_data,
  output logic [CNT_W-1:0]                 drop_cnt
);

  logic                      vld_d;
  logic                      inc_d;
  logic [NUM_SRC*DATA_W-1:0] data_d;
  logic                      cnt_en;
  logic [CNT_W-1:0]          cnt_d;

  always_comb begin
    vld_d  = |rel_mask;
    inc_d  = ~&rel_mask;
    for (int k = 0; k < NUM_SRC; k++) begin
      data_d[k*DATA_W +: DATA_W] = rel_mask[k] ? rel_data[k] : '0;
    end
    cnt_en = (drop_n != '0);
    cnt_d  = drop_cnt + CNT_W'(drop_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_valid      <= 1'b0;
      ev_ts         <= '0;
      ev_mask       <= '0;
      ev_incomplete <= 1'b0;
      ev_data       <= '0;
    end else begin
      ev_valid <= vld_d;
      if (vld_d) begin
        ev_ts         <= rel_ts;
        ev_mask       <= rel_mask;
        ev_incomplete <= inc_d;
        ev_data       <= data_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drop_cnt <= '0;
    end else if (cnt_en) begin
      drop_cnt <= cnt_d;
    end
  end

  AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(drop_cnt) |-> ($past(drop_n) != '0)); // R8

endmodule

// File: rtl/bx_event_builder.sv
module bx_event_builder
  import bxeb_pkg::*;
#(
  parameter int NUM_SRC  = 4,
  parameter int DATA_W   = 8,
  parameter int TS_W     = 12,
  parameter int NUM_SLOT = 8,
  parameter int LATENCY  = 5,
  parameter int CNT_W    = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        frag_vld,
  input  logic [NUM_SRC*TS_W-1:0]   frag_ts,
  input  logic [NUM_SRC*DATA_W-1:0] frag_data,
  input  logic [TS_W-1:0]           bx_now,
  output logic                      ev_valid,
  output logic [TS_W-1:0]           ev_ts,
  output logic [NUM_SRC-1:0]        ev_mask,
  output logic                      ev_incomplete,
  output logic [NUM_SRC*DATA_W-1:0] ev_data,
  output logic [CNT_W-1:0]          drop_cnt
);

  // LATENCY must stay below NUM_SLOT so a slot is free before its label recurs
  localparam int SLOT_W = $clog2(NUM_SLOT);
  localparam int DROP_W = $clog2(NUM_SRC + 1);

  logic [NUM_SLOT-1:0][NUM_SRC-1:0]             mask_q;
  logic [NUM_SLOT-1:0][NUM_SRC-1:0][DATA_W-1:0] data_q;
  frag_verdict_e                                verdict [NUM_SRC];
  logic [NUM_SRC-1:0][SLOT_W-1:0]               slot_idx;
  logic [NUM_SRC-1:0]                           take;
  logic [NUM_SRC-1:0][DATA_W-1:0]               take_data;
  logic [TS_W-1:0]                              rel_ts;
  logic [SLOT_W-1:0]                            rel_slot;
  logic [DROP_W-1:0]                            drop_n;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    logic [NUM_SLOT-1:0] col;

    always_comb begin
      for (int s = 0; s < NUM_SLOT; s++) begin
        col[s] = mask_q[s][k];
      end
    end

    bxeb_frag_gate #(
      .TS_W     (TS_W),
      .NUM_SLOT (NUM_SLOT),
      .LATENCY  (LATENCY)
    ) u_gate (
      .frag_vld (frag_vld[k]),
      .frag_ts  (frag_ts[k*TS_W +: TS_W]),
      .bx_now   (bx_now),
      .slot_has (col),
      .verdict  (verdict[k]),
      .slot_idx (slot_idx[k])
    );

    assign take[k]      = (verdict[k] == FR_TAKE);
    assign take_data[k] = frag_data[k*DATA_W +: DATA_W];
  end

  // The label whose fixed wait ends on this edge
  always_comb begin
    rel_ts   = bx_now - TS_W'(LATENCY);
    rel_slot = rel_ts[SLOT_W-1:0];
    drop_n   = '0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (verdict[k] == FR_LATE || verdict[k] == FR_DUP) begin
        drop_n = drop_n + DROP_W'(1);
      end
    end
  end

  bxeb_slot_bank #(
    .NUM_SRC  (NUM_SRC),
    .NUM_SLOT (NUM_SLOT),
    .DATA_W   (DATA_W)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .take_slot (slot_idx),
    .take_data (take_data),
    .rel_slot  (rel_slot),
    .mask_q    (mask_q),
    .data_q    (data_q)
  );

  bxeb_emit #(
    .NUM_SRC (NUM_SRC),
    .TS_W    (TS_W),
    .DATA_W  (DATA_W),
    .CNT_W   (CNT_W)
  ) u_emit (
    .clk           (clk),
    .rst_n         (rst_n),
    .rel_ts        (rel_ts),
    .rel_mask      (mask_q[rel_slot]),
    .rel_data      (data_q[rel_slot]),
    .drop_n        (drop_n),
    .ev_valid      (ev_valid),
    .ev_ts         (ev_ts),
    .ev_mask       (ev_mask),
    .ev_incomplete (ev_incomplete),
    .ev_data       (ev_data),
    .drop_cnt      (drop_cnt)
  );

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> (ev_ts == $past(bx_now) - TS_W'(LATENCY))); // R4

  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && $past(ev_valid)) |-> (ev_ts != $past(ev_ts))); // R4

endmodule

// File: tb/bx_event_builder_bench.sv
module bx_event_builder_bench;

  localparam int NS   = 4;
  localparam int DW   = 8;
  localparam int TW   = 12;
  localparam int NSL  = 8;
  localparam int LAT  = 5;
  localparam int CW   = 16;
  localparam int TMOD = 1 << TW;

  logic              clk;
  logic              rst_n;
  logic [NS-1:0]     frag_vld;
  logic [NS*TW-1:0]  frag_ts;
  logic [NS*DW-1:0]  frag_data;
  logic [TW-1:0]     bx_now;
  logic              ev_valid;
  logic [TW-1:0]     ev_ts;
  logic [NS-1:0]     ev_mask;
  logic              ev_incomplete;
  logic [NS*DW-1:0]  ev_data;
  logic [CW-1:0]     drop_cnt;

  int    vecs;
  int    errs;
  string scen;

  // Reference model: per-label presence and payload
  int unsigned     mmask [int];
  logic [NS*DW-1:0] mdat [int];
  logic             exp_valid;
  logic [TW-1:0]    exp_ts;
  logic [NS-1:0]    exp_mask;
  logic             exp_inc;
  logic [NS*DW-1:0] exp_data;
  logic [CW-1:0]    exp_drop;

  bx_event_builder #(
    .NUM_SRC (NS), .DATA_W (DW), .TS_W (TW),
    .NUM_SLOT (NSL), .LATENCY (LAT), .CNT_W (CW)
  ) u_bx_event_builder (
    .clk (clk), .rst_n (rst_n), .frag_vld (frag_vld), .frag_ts (frag_ts),
    .frag_data (frag_data), .bx_now (bx_now), .ev_valid (ev_valid),
    .ev_ts (ev_ts), .ev_mask (ev_mask), .ev_incomplete (ev_incomplete),
    .ev_data (ev_data), .drop_cnt (drop_cnt)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: run did not finish (scenario %s)", scen);
    summary();
    $finish;
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s [%s] bx=%0d actual=%0h expected=%0h", req, scen, bx_now, act, exp);
    end
  endtask

  // Fragment from source k, labelled 'age' crossings before the current counter
  task automatic put(int k, int age, logic [DW-1:0] d);
    frag_vld[k] = 1'b1;
    frag_ts[k*TW +: TW] = TW'((int'(bx_now) - age + 2 * TMOD) % TMOD);
    frag_data[k*DW +: DW] = d;
  endtask

  task automatic model_edge();
    int rel;
    rel = (int'(bx_now) - LAT + TMOD) % TMOD;
    exp_valid = 1'b0;
    if (mmask.exists(rel)) begin
      exp_valid = 1'b1;
      exp_ts    = TW'(rel);
      exp_mask  = NS'(mmask[rel]);
      exp_inc   = (exp_mask != '1);
      exp_data  = mdat[rel];
      mmask.delete(rel);
      mdat.delete(rel);
    end
    for (int k = 0; k < NS; k++) begin
      if (frag_vld[k]) begin
        int ts;
        int age;
        ts  = int'(frag_ts[k*TW +: TW]);
        age = (int'(bx_now) - ts + TMOD) % TMOD;
        if (age >= LAT) begin
          exp_drop = exp_drop + 1'b1;
        end else if (mmask.exists(ts) && mmask[ts][k]) begin
          exp_drop = exp_drop + 1'b1;
        end else begin
          if (!mmask.exists(ts)) begin
            mmask[ts] = 0;
            mdat[ts]  = '0;
          end
          mmask[ts] = mmask[ts] | (32'd1 << k);
          mdat[ts][k*DW +: DW] = frag_data[k*DW +: DW];
        end
      end
    end
  endtask

  task automatic compare();
    chk("R4/R10 ev_valid", 64'(ev_valid), 64'(exp_valid));
    if (exp_valid && ev_valid) begin
      chk("R4 ev_ts", 64'(ev_ts), 64'(exp_ts));
      chk("R3 ev_mask", 64'(ev_mask), 64'(exp_mask));
      chk("R5 ev_incomplete", 64'(ev_incomplete), 64'(exp_inc));
      chk("R9 ev_data", 64'(ev_data), 64'(exp_data));
    end
    chk("R8 drop_cnt", 64'(drop_cnt), 64'(exp_drop));
  endtask

  // Inputs are set at a falling edge; the model predicts the next rising edge
  task automatic cycle();
    model_edge();
    @(posedge clk);
    @(negedge clk);
    compare();
    bx_now   = bx_now + 1'b1;
    frag_vld = '0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  initial begin
    vecs      = 0;
    errs      = 0;
    scen      = "reset";
    rst_n     = 1'b0;
    frag_vld  = '0;
    frag_ts   = '0;
    frag_data = '0;
    bx_now    = TW'(TMOD - 40);
    exp_drop  = '0;
    exp_valid = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs idle while reset is held
    chk("R1 ev_valid in reset", 64'(ev_valid), 64'd0);
    chk("R1 drop_cnt in reset", 64'(drop_cnt), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ev_valid after reset", 64'(ev_valid), 64'd0);
    chk("R1 drop_cnt after reset", 64'(drop_cnt), 64'd0);
    idle(LAT + 2);

    // R3, R6: all sources report one label over three cycles; full early, held
    scen = "full event held R6";
    put(0, 0, 8'h11); cycle();
    put(1, 1, 8'h22); put(2, 1, 8'h33); cycle();
    put(3, 2, 8'h44); cycle();
    idle(LAT + 2);

    // R5, R9: partial event gets incomplete flag and zeroed fields
    scen = "partial event R5 R9";
    put(1, 0, 8'hA1); cycle();
    put(3, 1, 8'hB3); cycle();
    idle(LAT + 2);

    // R2: last admissible age, then exactly LATENCY old in the release cycle
    scen = "window edge R2";
    put(0, 0, 8'h01); cycle();
    idle(LAT - 2);
    put(1, LAT - 1, 8'h02); put(2, 0, 8'h07); cycle();
    put(2, LAT, 8'h03); put(3, LAT - 1, 8'h04); put(0, -3, 8'h05); cycle();
    idle(LAT + 2);

    // R7: same source twice for one label keeps the first payload
    scen = "duplicate R7";
    put(0, 0, 8'hAA); cycle();
    put(0, 1, 8'h55); put(2, 1, 8'h66); cycle();
    idle(LAT + 2);

    // R11, R8: one cycle with two accepted and two dropped fragments
    scen = "same cycle R11 R8";
    put(0, 0, 8'hC0); put(1, 1, 8'hC1); put(2, 7, 8'hC2); put(3, 9, 8'hC3); cycle();
    put(2, 1, 8'hD2); put(3, 0, 8'hD3); cycle();
    idle(LAT + 2);

    // R10: nothing delivered, nothing emitted
    scen = "empty crossings R10";
    idle(2 * NSL);

    // Mixed traffic across a counter wrap: R2 R3 R4 R5 R7 R8 R9 R11
    scen = "random traffic";
    for (int n = 0; n < 5000; n++) begin
      for (int k = 0; k < NS; k++) begin
        if (($urandom % 100) < 35) begin
          int a;
          a = int'($urandom % (LAT + 3));
          if (($urandom % 20) == 0) a = -1 - int'($urandom % 4);
          put(k, a, DW'($urandom));
        end
      end
      cycle();
    end
    idle(LAT + 2);

    summary();
    $finish;
  end

endmodule